// File: doc/BRIEF.md
# Nine-bit Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a single line and turns them into a stored byte, a status bit and a sticky receive-complete flag. A timing tick arrives at sixteen times the bit rate, so each bit spans sixteen ticks. A falling edge on the line, while reception is enabled, restarts the bit counter and begins a frame. The start bit is confirmed at its midpoint. Each data bit is then sampled once at its midpoint, least significant bit first.

There are two frame lengths. The short frame has eight data bits and is ten bits long. The long frame has nine data bits and is eleven bits long. The long frame has two variants. The first is an address-filtering variant for multi-drop links: a frame whose ninth bit is clear is discarded without raising the flag. The second variant accepts every frame. The status bit holds either the received ninth bit or a parity-error indication, depending on mode and parity settings. The flag rises earlier for short frames (at the middle of the stop bit) than for long frames (after the stop bit has ended). The host clears the flag with a one-cycle strobe.

Top module: `mp_serial_rx`

## Requirements
- R1: A falling edge on `rx_line` while `rx_en` is 1 starts a frame. If the line is high at the 8th tick of the start bit, the frame is abandoned and no output changes.
- R2: While `rx_en` is 0, a frame in progress is abandoned and new falling edges are ignored. No output changes.
- R3: `mode_sel` selects the frame format: 2'b10 is the filtered 9-bit format, 2'b11 is the unfiltered 9-bit format, and 2'b00 or 2'b01 is the 8-bit format. Bits arrive LSB first. In the 8-bit format with parity off, `rx_data` takes all eight bits and `ri` is set.
- R4: In the 8-bit format, `ri` is set a few clocks after the 8th tick of the stop bit. In both 9-bit formats, `ri` is set a few clocks after the 16th tick of the stop bit. Either way, at tick 12 of the stop bit, `ri` is 1 for 8-bit frames and still 0 for 9-bit frames.
- R5: In format 2'b10, a frame whose ninth bit is 1 loads `rx_data` (`rx_bit9` = 1) and sets `ri`. A frame whose ninth bit is 0 leaves `rx_data`, `rx_bit9` and `ri` untouched. `par_en` has no effect in this format.
- R6: In format 2'b11, every completed frame loads `rx_data` and sets `ri`, whatever the ninth bit is.
- R7: With `par_en` = 0, `rx_bit9` holds the received ninth bit in format 2'b11 and is 0 after an 8-bit frame.
- R8: In format 2'b11 with `par_en` = 1, `rx_bit9` is 1 when the ninth bit is wrong. The ninth bit is correct when the count of ones in the eight data bits plus the ninth bit is even (`par_odd` = 0) or odd (`par_odd` = 1).
- R9: In the 8-bit format with `par_en` = 1, bit 7 is parity over bits 6..0 under the same even/odd rule. It is still stored in `rx_data[7]`, and `rx_bit9` is 1 when it is wrong.
- R10: `frame_err` takes the inverse of the sampled stop bit at every completed frame, including frames dropped under R5.
- R11: `ri` stays 1 until `ri_clr` is pulsed; the clear acts on the next clock. A frame acceptance in the same cycle wins over the clear.
- R12: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Reception enable |
| mode_sel | input | 2 | Frame format select (see R3) |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| ri_clr | input | 1 | Clears the receive-complete flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit or parity-error status |
| ri | output | 1 | Sticky receive-complete flag |
| frame_err | output | 1 | Stop bit of the last completed frame was low |

## Verification
The line passes through a two-stage synchronizer and an edge register, so the bit counter restarts about three clocks after a falling edge. A result reaches the outputs two clocks after the deciding tick. The short-format flag is therefore due about 8 ticks plus five clocks into the stop bit, and the long-format flag about 16 ticks plus five clocks in. The bench holds each bit for 16 ticks of four clocks and probes `ri` 48 clocks into the stop bit, which falls between those two instants. Data, status and error bits are compared 40 clocks after the stop bit ends, and a clear strobe is checked one clock after it is applied.

// File: rtl/mpsrx_pkg.sv
// Shared types for the nine-bit serial receiver.
// Assumes: a frame-format code of two bits, where bit 1 means a nine-bit frame.
package mpsrx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_e;

    typedef enum logic [1:0] {
        FMT_SHORT0 = 2'b00,
        FMT_SHORT  = 2'b01,
        FMT_FILT   = 2'b10,
        FMT_ALL    = 2'b11
    } rx_fmt_e;

    // True when the format code selects a nine-bit frame.
    function automatic logic fmt_is_long(input logic [1:0] fmt);
        return fmt[1];
    endfunction

endpackage

// File: rtl/mpsrx_sync.sv
// Line synchronizer and falling-edge detector.
// Assumes: the line idles high; the reset value is high, so a frame cannot
// appear to start when reset is released.
module mpsrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);

    logic [STAGES:0] pipe;

    // Shift the asynchronous line through the synchronizer stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], line_in};
    end

    assign line_s = pipe[STAGES-1];
    assign fall   = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/mpsrx_bitclk.sv
// Oversampling bit-phase counter.
// It counts ticks within each bit period and marks the sampling tick and the
// last tick of each bit. A restart pulse realigns the count to a start edge.
// Assumes: OVS >= 4; restart takes priority over a coincident tick.
module mpsrx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic mid,
    output logic last
);

    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_PH  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_PH = CW'(OVS - 1);

    logic [CW-1:0] phase;

    // Advance the phase on each tick and wrap at the end of a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (tick)    phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
    end

    assign mid  = tick && !restart && (phase == MID_PH);
    assign last = tick && !restart && (phase == LAST_PH);

endmodule

// File: rtl/mpsrx_deframe.sv
// Frame sequencer.
// It checks the start bit, shifts in the data bits LSB first and samples the
// stop bit. It then emits a one-cycle done pulse with the captured word.
// Short frames finish at the stop-bit midpoint. Long frames finish at the
// stop bit's last tick.
// Assumes: mode is stable at the start edge; the format is latched then.
module mpsrx_deframe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              line_s,
    input  logic              fall,
    input  logic              mid,
    input  logic              last,
    input  logic [1:0]        mode,
    output logic              restart,
    output logic              done,
    output logic [DATA_W:0]   word,
    output logic [1:0]        fmt_q,
    output logic              stop_q
);
    import mpsrx_pkg::*;

    localparam int SW  = DATA_W + 1;
    localparam int BCW = $clog2(SW + 1);

    fr_state_e         st;
    logic [BCW-1:0]    nbit;
    logic [BCW-1:0]    need;
    logic [DATA_W:0]   sh;
    logic              stop_seen;

    assign restart = (st == FR_IDLE) && fall && rx_en;
    assign need    = fmt_is_long(fmt_q) ? BCW'(SW) : BCW'(DATA_W);

    // Walk one frame: start check, data shifting, stop sampling and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= FR_IDLE;
            nbit      <= '0;
            sh        <= '0;
            fmt_q     <= '0;
            stop_q    <= 1'b1;
            stop_seen <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                st <= FR_IDLE;
            end else begin
                case (st)
                    FR_IDLE: begin
                        if (fall) begin
                            st    <= FR_START;
                            fmt_q <= mode;
                            nbit  <= '0;
                        end
                    end
                    FR_START: begin
                        if (mid) st <= line_s ? FR_IDLE : FR_DATA;
                    end
                    FR_DATA: begin
                        if (mid) begin
                            sh   <= {line_s, sh[DATA_W:1]};
                            nbit <= nbit + 1'b1;
                            if (nbit == need - 1'b1) begin
                                st        <= FR_STOP;
                                stop_seen <= 1'b0;
                            end
                        end
                    end
                    FR_STOP: begin
                        if (mid) begin
                            stop_q    <= line_s;
                            stop_seen <= 1'b1;
                            if (!fmt_is_long(fmt_q)) begin
                                done <= 1'b1;
                                st   <= FR_IDLE;
                            end
                        end else if (last && stop_seen) begin
                            done <= 1'b1;
                            st   <= FR_IDLE;
                        end
                    end
                    default: st <= FR_IDLE;
                endcase
            end
        end
    end

    // Align the captured bits: a short frame sits in the top DATA_W bits of the shifter.
    always_comb begin
        if (fmt_is_long(fmt_q)) word = sh;
        else                    word = {1'b0, sh[DATA_W:1]};
    end

endmodule

// File: rtl/mpsrx_result.sv
// Result stage.
// It applies the format's acceptance rule, computes the status bit (ninth bit
// or parity error) and holds the data, status, flag and framing-error
// registers.
// Assumes: par_en and par_odd are stable while a frame is received; DATA_W >= 2.
module mpsrx_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W:0]   word,
    input  logic [1:0]        fmt_q,
    input  logic              stop_q,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ri_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              ri,
    output logic              frame_err
);
    import mpsrx_pkg::*;

    logic [DATA_W-1:0] dat;
    logic              ninth;
    logic              perr_short;
    logic              perr_long;
    logic              status;
    logic              accept;

    assign dat   = word[DATA_W-1:0];
    assign ninth = word[DATA_W];

    // Parity errors: the short format checks its top bit, the long format its ninth bit.
    assign perr_short = dat[DATA_W-1] ^ (^dat[DATA_W-2:0]) ^ par_odd;
    assign perr_long  = ninth ^ (^dat) ^ par_odd;

    // Choose what the status bit reports for the latched format.
    always_comb begin
        case (fmt_q)
            FMT_FILT: status = ninth;
            FMT_ALL:  status = par_en ? perr_long : ninth;
            default:  status = par_en ? perr_short : 1'b0;
        endcase
    end

    assign accept = done && ((fmt_q != FMT_FILT) || ninth);

    // Record the stop-bit outcome of every completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)    frame_err <= 1'b0;
        else if (done) frame_err <= ~stop_q;
    end

    // Load the data and status registers from accepted frames only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
        end else if (accept) begin
            rx_data <= dat;
            rx_bit9 <= status;
        end
    end

    // Hold the receive-complete flag until the host clears it; a new acceptance wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      ri <= 1'b0;
        else if (accept) ri <= 1'b1;
        else if (ri_clr) ri <= 1'b0;
    end

endmodule

// File: rtl/mp_serial_rx.sv
// Top level of the nine-bit address-filtering serial receiver.
// It chains the synchronizer, the bit-phase counter, the frame sequencer and
// the result stage.
// Assumes: tick16 pulses for one clock at OVS times the bit rate, and the clock
// is several times faster than the tick.
module mp_serial_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_line,
    input  logic              rx_en,
    input  logic [1:0]        mode_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ri_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              ri,
    output logic              frame_err
);

    logic            line_s;
    logic            line_fall;
    logic            bit_restart;
    logic            bit_mid;
    logic            bit_last;
    logic            fr_done;
    logic [DATA_W:0] fr_word;
    logic [1:0]      fr_fmt;
    logic            fr_stop;

    mpsrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .line_s  (line_s),
        .fall    (line_fall)
    );

    mpsrx_bitclk #(.OVS(OVS)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (bit_restart),
        .tick    (tick16),
        .mid     (bit_mid),
        .last    (bit_last)
    );

    mpsrx_deframe #(.DATA_W(DATA_W)) u_deframe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .line_s  (line_s),
        .fall    (line_fall),
        .mid     (bit_mid),
        .last    (bit_last),
        .mode    (mode_sel),
        .restart (bit_restart),
        .done    (fr_done),
        .word    (fr_word),
        .fmt_q   (fr_fmt),
        .stop_q  (fr_stop)
    );

    mpsrx_result #(.DATA_W(DATA_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (fr_done),
        .word      (fr_word),
        .fmt_q     (fr_fmt),
        .stop_q    (fr_stop),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .ri_clr    (ri_clr),
        .rx_data   (rx_data),
        .rx_bit9   (rx_bit9),
        .ri        (ri),
        .frame_err (frame_err)
    );

endmodule

// File: rtl/mpsrx_checker.sv
// Property checker for the serial receiver. It is attached to the top level by
// the bind statement at the end of this file.
// Assumes: it observes the frame-done pulse and latched format inside the top.
module mpsrx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              ri_clr,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              ri,
    input logic              frame_err,
    input logic              done,
    input logic              ninth,
    input logic [1:0]        fmt
);

    // R11: the flag holds while no clear is requested
    assert_ri_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ri && !ri_clr |=> ri);

    // R11: a clear with no completing frame drops the flag
    assert_ri_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ri_clr && !done |=> !ri);

    // R2: with reception disabled for two cycles, the flag cannot rise
    assert_no_rise_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && $past(!rx_en)) |-> !$rose(ri));

    // R5: a filtered frame whose ninth bit is clear changes nothing visible
    assert_filter_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fmt == 2'b10) && !ninth |=> $stable(rx_data) && $stable(rx_bit9) && !$rose(ri));

    // R6: an unfiltered long frame always raises the flag
    assert_all_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fmt == 2'b11) |=> ri);

    // R5: data only changes together with a raised flag
    assert_data_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> ri);

    // R10: the framing-error bit only moves one cycle after a completed frame
    assert_fe_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_err) |-> $past(done));

endmodule

bind mp_serial_rx mpsrx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .ri_clr    (ri_clr),
    .rx_data   (rx_data),
    .rx_bit9   (rx_bit9),
    .ri        (ri),
    .frame_err (frame_err),
    .done      (fr_done),
    .ninth     (fr_word[DATA_W]),
    .fmt       (fr_fmt)
);

// File: tb/mp_serial_rx_test.sv
// Self-checking bench for the serial receiver: directed corner cases followed by
// seeded random frames, compared against a bench-side model of the requirements.
module mp_serial_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int STOP_PROBE = 48;
    localparam int N_RANDOM   = 100;
    localparam int WATCHDOG   = 199000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       ri_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       ri;
    logic       frame_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    logic [7:0] m_data = '0;
    logic       m_rb8  = 1'b0;
    logic       m_ri   = 1'b0;
    logic       m_fe   = 1'b0;

    mp_serial_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .rx_line   (rx_line),
        .rx_en     (rx_en),
        .mode_sel  (mode_sel),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .ri_clr    (ri_clr),
        .rx_data   (rx_data),
        .rx_bit9   (rx_bit9),
        .ri        (ri),
        .frame_err (frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Oversampling tick: one clock in every TICK_DIV, changed at the falling edge.
    initial begin : tick_gen
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c++;
            tick16 = ((c % TICK_DIV) == 0);
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "rx_data", int'(rx_data), int'(m_data));
        check(req, "rx_bit9", int'(rx_bit9), int'(m_rb8));
        check(req, "ri", int'(ri), int'(m_ri));
        check("R10", "frame_err", int'(frame_err), int'(m_fe));
    endtask

    // Expected outputs after one completed frame.
    task automatic model(input logic [1:0] md, input logic pe, input logic po,
                         input logic [8:0] d9, input logic stop);
        m_fe = !stop;
        case (md)
            2'b10: begin
                if (d9[8]) begin
                    m_data = d9[7:0];
                    m_rb8  = 1'b1;
                    m_ri   = 1'b1;
                end
            end
            2'b11: begin
                m_data = d9[7:0];
                m_rb8  = pe ? (d9[8] != ((^d9[7:0]) ^ po)) : d9[8];
                m_ri   = 1'b1;
            end
            default: begin
                m_data = d9[7:0];
                m_rb8  = pe ? (d9[7] != ((^d9[6:0]) ^ po)) : 1'b0;
                m_ri   = 1'b1;
            end
        endcase
    endtask

    function automatic string tag_for(input logic [1:0] md, input logic pe);
        if (md == 2'b10) return "R5";
        if (md == 2'b11) return pe ? "R8" : "R7";
        return pe ? "R9" : "R3";
    endfunction

    // Drive one frame; abort_at >= 0 drops rx_en at that data bit.
    task automatic send_frame(input logic [1:0] md, input logic pe, input logic po,
                              input logic [8:0] d9, input logic stop,
                              input int abort_at, input bit probe);
        int nb;
        nb       = md[1] ? 9 : 8;
        mode_sel = md;
        par_en   = pe;
        par_odd  = po;
        rx_line  = 1'b0;
        hold(BIT_CLKS);
        for (int i = 0; i < nb; i++) begin
            if (i == abort_at) rx_en = 1'b0;
            rx_line = d9[i];
            hold(BIT_CLKS);
        end
        rx_line = stop;
        if (probe) begin
            hold(STOP_PROBE);
            check("R4", "ri at stop tick 12", int'(ri), md[1] ? 0 : 1);
            hold(BIT_CLKS - STOP_PROBE);
        end else begin
            hold(BIT_CLKS);
        end
        rx_line = 1'b1;
        hold(40);
    endtask

    task automatic full_frame(input logic [1:0] md, input logic pe, input logic po,
                              input logic [8:0] d9, input logic stop, input string req);
        bit probe;
        probe = !m_ri && !(md == 2'b10 && !d9[8]);
        send_frame(md, pe, po, d9, stop, -1, probe);
        model(md, pe, po, d9, stop);
        check_all(req);
    endtask

    task automatic clear_ri();
        ri_clr = 1'b1;
        hold(1);
        ri_clr = 1'b0;
        m_ri   = 1'b0;
        check("R11", "ri after clear", int'(ri), 0);
    endtask

    task automatic random_frame();
        logic [1:0] md;
        logic       pe;
        logic       po;
        logic [8:0] d9;
        logic       stop;
        md   = 2'($urandom_range(0, 3));
        pe   = 1'($urandom_range(0, 1));
        po   = 1'($urandom_range(0, 1));
        d9   = 9'($urandom_range(0, 511));
        stop = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 1) == 1) clear_ri();
        full_frame(md, pe, po, d9, stop, tag_for(md, pe));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        hold(5);
        check_all("R12");
        rst_n = 1'b1;
        rx_en = 1'b1;
        hold(20);

        // R6 / R4: unfiltered long frame with ninth bit clear still completes late
        full_frame(2'b11, 1'b0, 1'b0, 9'h0A5, 1'b1, "R6");
        // R11: the flag stays set with no clear
        hold(300);
        check("R11", "ri held", int'(ri), 1);
        clear_ri();
        // R4 / R3: short frame completes at the stop midpoint
        full_frame(2'b01, 1'b0, 1'b0, 9'h03C, 1'b1, "R3");
        clear_ri();
        // R5: filtered frame with ninth bit clear is dropped, then one with it set is taken
        full_frame(2'b10, 1'b1, 1'b0, 9'h055, 1'b1, "R5");
        full_frame(2'b10, 1'b0, 1'b0, 9'h1C3, 1'b1, "R5");
        clear_ri();
        // R1: a short low glitch is rejected
        rx_line = 1'b0;
        hold(16);
        rx_line = 1'b1;
        hold(200);
        check_all("R1");
        // R2: abort mid-frame, then a frame while disabled
        send_frame(2'b11, 1'b0, 1'b0, 9'h1FF, 1'b1, 3, 1'b0);
        check_all("R2");
        send_frame(2'b01, 1'b0, 1'b0, 9'h012, 1'b1, -1, 1'b0);
        check_all("R2");
        rx_en = 1'b1;
        hold(20);
        // R8: even parity right then wrong, odd parity right
        full_frame(2'b11, 1'b1, 1'b0, 9'h003, 1'b1, "R8");
        full_frame(2'b11, 1'b1, 1'b0, 9'h103, 1'b1, "R8");
        full_frame(2'b11, 1'b1, 1'b1, 9'h103, 1'b1, "R8");
        // R9: short format parity in bit 7
        full_frame(2'b01, 1'b1, 1'b0, 9'h081, 1'b1, "R9");
        full_frame(2'b00, 1'b1, 1'b1, 9'h001, 1'b1, "R9");
        // R7: ninth bit reported with parity off
        full_frame(2'b11, 1'b0, 1'b1, 9'h100, 1'b1, "R7");
        // R10: framing errors in both lengths, then a clean frame clears it
        full_frame(2'b11, 1'b0, 1'b0, 9'h0F0, 1'b0, "R10");
        full_frame(2'b01, 1'b0, 1'b0, 9'h00F, 1'b0, "R10");
        full_frame(2'b10, 1'b0, 1'b0, 9'h011, 1'b1, "R10");

        for (int k = 0; k < N_RANDOM; k++) random_frame();

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule